// File: doc/BRIEF.md
# Programmed I/O Flag Unit

This block gives an accumulator-based processor one byte-wide input channel and one byte-wide output channel. Each channel holds a character register and a ready flag. The processor and an external device each set or clear these flags. This lets a device and a polling loop pass characters without losing or repeating one. The block also holds an interrupt-enable bit. It raises an interrupt request whenever interrupts are enabled and either channel wants attention.

The processor's control sequencer asserts `exec_io` during the step in which an I/O instruction executes. It also presents the six selector bits of that instruction. In the same cycle the block returns:
- a new accumulator value with its load strobe,
- a program-counter skip request,
- a sequence-counter clear.

Flag, register and enable updates take effect at the next clock edge. On the other side, the device writes characters in with a strobe and signals that it has taken the output character with an acknowledge.

Top module: `pio_flag_unit`

## Requirements
- R1: During and after reset, `in_flag` is 0, `out_flag` is 1, `int_en` is 0 and `dev_out_data` is 0.
- R2: The `io_sel` bit positions are: bit 5 read input, bit 4 write output, bit 3 skip if input ready, bit 2 skip if output ready, bit 1 enable interrupts, bit 0 disable interrupts. A command acts only when `exec_io` is 1 and exactly one bit is set. Any other selector value has no effect on any output or state.
- R3: A read-input command drives `acc_load` high in the same cycle, with `acc_out` equal to the upper accumulator byte from `acc_in` joined to the held input character. At the next edge it clears `in_flag`.
- R4: A write-output command loads `acc_in[7:0]` into `dev_out_data` and clears `out_flag` at the next edge.
- R5: The skip-if-input-ready command drives `pc_skip` in the same cycle exactly when `in_flag` is 1. The skip-if-output-ready command does the same exactly when `out_flag` is 1.
- R6: The enable command sets `int_en` and the disable command clears it, at the next edge.
- R7: A `dev_in_strobe` while `in_flag` is 0 captures `dev_in_data` and sets `in_flag`. While `in_flag` is 1 the strobe changes neither the held character nor the flag.
- R8: A `dev_out_ack` while `out_flag` is 0 sets `out_flag`. While `out_flag` is 1 it has no effect.
- R9: When a device strobe is accepted in the same cycle as a read-input command, the command still returns the previously held character and `in_flag` ends at 1. When an acknowledge meets a write-output command, the new character is stored and `out_flag` ends at 0.
- R10: `irq` equals `int_en` AND (`in_flag` OR `out_flag`) at all times.
- R11: `seq_clr` equals `exec_io` in every cycle, for any selector value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_io | input | 1 | I/O instruction execute step is active |
| io_sel | input | 6 | Instruction selector bits, one-hot |
| acc_in | input | 16 | Current accumulator value |
| acc_out | output | 16 | Accumulator value to load |
| acc_load | output | 1 | Accumulator load strobe |
| pc_skip | output | 1 | Request to advance the program counter once more |
| seq_clr | output | 1 | Clear the sequence counter |
| dev_in_strobe | input | 1 | Device offers a new input character |
| dev_in_data | input | 8 | Character offered by the device |
| dev_out_ack | input | 1 | Device has taken the output character |
| dev_out_data | output | 8 | Held output character |
| in_flag | output | 1 | Input character is waiting |
| out_flag | output | 1 | Output register is free |
| int_en | output | 1 | Interrupts enabled |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends device strobes and acknowledges while the matching flag is in the wrong state. A design that accepted them would overwrite a waiting character, or mark the output free twice. That error shows up in a later read value and in the flag levels.

It applies selector codes with two bits set, and a valid code with `exec_io` low. A loosely decoded design would then skip, load the accumulator or move a flag.

It also collides each CPU command with the device event on the same channel. This exposes a wrong priority, which would lose a character or leave a stale flag. A read is issued with a non-zero upper accumulator byte, which catches a design that zeroes or shifts those bits.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
   localparam int OP_COUNT = 6;
   localparam int OP_RD  = 5;
   localparam int OP_WR  = 4;
   localparam int OP_SKR = 3;
   localparam int OP_SKW = 2;
   localparam int OP_EN  = 1;
   localparam int OP_DIS = 0;

   // field order follows selector bit order, MSB first
   typedef struct packed {
      logic rd;
      logic wr;
      logic skip_rd;
      logic skip_wr;
      logic en;
      logic dis;
   } io_cmd_t;
endpackage

// File: rtl/pio_decode.sv
`timescale 1ns/1ps
module pio_decode
   import pio_pkg::*;
(
   input  logic                exec_io,
   input  logic [OP_COUNT-1:0] io_sel,
   output io_cmd_t             cmd
);
   logic single_bit;

   always_comb begin
      single_bit = (io_sel != '0) && ((io_sel & (io_sel - 1'b1)) == '0);
      if (exec_io && single_bit) cmd = io_cmd_t'(io_sel);
      else                       cmd = '0;
   end
endmodule

// File: rtl/pio_in_chan.sv
`timescale 1ns/1ps
module pio_in_chan #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_strobe,
   input  logic [CHAR_W-1:0] dev_data,
   input  logic              cpu_take,
   output logic [CHAR_W-1:0] char_q,
   output logic              flag_q
);
   logic accept;
   assign accept = dev_strobe && !flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         char_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (accept) char_q <= dev_data;
         // an arriving character outranks the CPU's clear
         if (accept)        flag_q <= 1'b1;
         else if (cpu_take) flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pio_out_chan.sv
`timescale 1ns/1ps
module pio_out_chan #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_put,
   input  logic [CHAR_W-1:0] cpu_data,
   input  logic              dev_ack,
   output logic [CHAR_W-1:0] char_q,
   output logic              flag_q
);
   logic consume;
   assign consume = dev_ack && !flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         char_q <= '0;
         flag_q <= 1'b1;
      end else if (cpu_put) begin
         // a fresh character must not be marked as already taken
         char_q <= cpu_data;
         flag_q <= 1'b0;
      end else if (consume) begin
         flag_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pio_ien.sv
`timescale 1ns/1ps
module pio_ien #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   input  logic clr_en,
   output logic en_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= RST_VAL;
      else if (set_en) en_q <= 1'b1;
      else if (clr_en) en_q <= 1'b0;
   end
endmodule

// File: rtl/pio_flag_unit.sv
`timescale 1ns/1ps
module pio_flag_unit
   import pio_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CHAR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                exec_io,
   input  logic [OP_COUNT-1:0] io_sel,
   input  logic [WORD_W-1:0]   acc_in,
   output logic [WORD_W-1:0]   acc_out,
   output logic                acc_load,
   output logic                pc_skip,
   output logic                seq_clr,
   input  logic                dev_in_strobe,
   input  logic [CHAR_W-1:0]   dev_in_data,
   input  logic                dev_out_ack,
   output logic [CHAR_W-1:0]   dev_out_data,
   output logic                in_flag,
   output logic                out_flag,
   output logic                int_en,
   output logic                irq
);
   localparam int HI_W = WORD_W - CHAR_W;

   initial begin
      assert (CHAR_W >= 1 && CHAR_W <= WORD_W)
         else $error("pio_flag_unit: CHAR_W must be in 1..WORD_W");
   end

   io_cmd_t           cmd;
   logic [CHAR_W-1:0] in_char;

   pio_decode u_dec (
      .exec_io (exec_io),
      .io_sel  (io_sel),
      .cmd     (cmd)
   );

   pio_in_chan #(.CHAR_W(CHAR_W)) u_in (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_strobe (dev_in_strobe),
      .dev_data   (dev_in_data),
      .cpu_take   (cmd.rd),
      .char_q     (in_char),
      .flag_q     (in_flag)
   );

   pio_out_chan #(.CHAR_W(CHAR_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_put  (cmd.wr),
      .cpu_data (acc_in[CHAR_W-1:0]),
      .dev_ack  (dev_out_ack),
      .char_q   (dev_out_data),
      .flag_q   (out_flag)
   );

   pio_ien #(.RST_VAL(1'b0)) u_ien (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (cmd.en),
      .clr_en (cmd.dis),
      .en_q   (int_en)
   );

   generate
      if (HI_W == 0) begin : g_full_word
         assign acc_out = in_char;
      end else begin : g_keep_high
         assign acc_out = {acc_in[WORD_W-1:CHAR_W], in_char};
      end
   endgenerate

   assign acc_load = cmd.rd;
   assign pc_skip  = (cmd.skip_rd && in_flag) || (cmd.skip_wr && out_flag);
   assign seq_clr  = exec_io;
   assign irq      = int_en && (in_flag || out_flag);
endmodule

// File: rtl/pio_flag_unit_chk.sv
`timescale 1ns/1ps
module pio_flag_unit_chk #(
   parameter int WORD_W = 16,
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_io,
   input logic [5:0]        io_sel,
   input logic [WORD_W-1:0] acc_in,
   input logic              acc_load,
   input logic              pc_skip,
   input logic              dev_in_strobe,
   input logic [CHAR_W-1:0] dev_in_data,
   input logic              dev_out_ack,
   input logic [CHAR_W-1:0] dev_out_data,
   input logic              in_flag,
   input logic              out_flag,
   input logic              int_en,
   input logic [CHAR_W-1:0] in_char
);
   logic one_cmd;
   assign one_cmd = exec_io && $onehot(io_sel);

   // R2
   bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_io && !$onehot(io_sel)) |-> (!acc_load && !pc_skip));

   // R3
   rd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one_cmd && io_sel[5] && !dev_in_strobe) |=> !in_flag);

   // R4
   wr_loads_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one_cmd && io_sel[4]) |=> (!out_flag && dev_out_data == $past(acc_in[CHAR_W-1:0])));

   // R5
   skip_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_skip |-> exec_io);

   // R6
   en_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one_cmd && io_sel[1]) |=> int_en);

   // R6
   dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one_cmd && io_sel[0]) |=> !int_en);

   // R7
   strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_in_strobe && !in_flag) |=> (in_flag && in_char == $past(dev_in_data)));

   // R7
   strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_in_strobe && in_flag) |=> $stable(in_char));

   // R8
   ack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_out_ack && !out_flag && !(one_cmd && io_sel[4])) |=> out_flag);

   // R9
   strobe_beats_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one_cmd && io_sel[5] && dev_in_strobe && !in_flag) |=> in_flag);
endmodule

bind pio_flag_unit pio_flag_unit_chk #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .exec_io       (exec_io),
   .io_sel        (io_sel),
   .acc_in        (acc_in),
   .acc_load      (acc_load),
   .pc_skip       (pc_skip),
   .dev_in_strobe (dev_in_strobe),
   .dev_in_data   (dev_in_data),
   .dev_out_ack   (dev_out_ack),
   .dev_out_data  (dev_out_data),
   .in_flag       (in_flag),
   .out_flag      (out_flag),
   .int_en        (int_en),
   .in_char       (in_char)
);

// File: tb/sim_pio_flag_unit.sv
`timescale 1ns/1ps
module sim_pio_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        exec_io;
   logic [5:0]  io_sel;
   logic [15:0] acc_in;
   logic [15:0] acc_out;
   logic        acc_load, pc_skip, seq_clr;
   logic        dev_in_strobe;
   logic [7:0]  dev_in_data;
   logic        dev_out_ack;
   logic [7:0]  dev_out_data;
   logic        in_flag, out_flag, int_en, irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   pio_flag_unit u0 (
      .clk (clk), .rst_n (rst_n), .exec_io (exec_io), .io_sel (io_sel),
      .acc_in (acc_in), .acc_out (acc_out), .acc_load (acc_load),
      .pc_skip (pc_skip), .seq_clr (seq_clr), .dev_in_strobe (dev_in_strobe),
      .dev_in_data (dev_in_data), .dev_out_ack (dev_out_ack),
      .dev_out_data (dev_out_data), .in_flag (in_flag), .out_flag (out_flag),
      .int_en (int_en), .irq (irq)
   );

   typedef struct packed {
      logic        ex;
      logic [5:0]  sel;
      logic [15:0] acc;
      logic        stb;
      logic [7:0]  din;
      logic        ack;
      logic        e_load;
      logic [15:0] e_acc;
      logic        e_skip;
      logic        e_fgi;
      logic        e_fgo;
      logic        e_ien;
      logic [7:0]  e_outr;
      logic        e_irq;
   } vec_t;

   // sel bits: 20 read, 10 write, 08 skip-rd, 04 skip-wr, 02 enable, 01 disable
   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{1'b1,6'h08,16'h1234,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b0,8'h00,1'b0},
      '{1'b1,6'h04,16'h1234,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b1, 1'b0,1'b1,1'b0,8'h00,1'b0},
      '{1'b1,6'h02,16'h0000,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b1,8'h00,1'b1},
      '{1'b1,6'h10,16'hABCD,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b1,8'hCD,1'b0},
      '{1'b0,6'h00,16'h0000,1'b0,8'h00,1'b1, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b1,8'hCD,1'b1},
      '{1'b0,6'h00,16'h0000,1'b1,8'h5A,1'b0, 1'b0,16'h0000,1'b0, 1'b1,1'b1,1'b1,8'hCD,1'b1},
      '{1'b0,6'h00,16'h0000,1'b1,8'h77,1'b0, 1'b0,16'h0000,1'b0, 1'b1,1'b1,1'b1,8'hCD,1'b1},
      '{1'b1,6'h08,16'h0000,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b1, 1'b1,1'b1,1'b1,8'hCD,1'b1},
      '{1'b1,6'h20,16'h9900,1'b0,8'h00,1'b0, 1'b1,16'h995A,1'b0, 1'b0,1'b1,1'b1,8'hCD,1'b1},
      '{1'b0,6'h00,16'h0000,1'b0,8'h00,1'b1, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b1,8'hCD,1'b1},
      '{1'b1,6'h01,16'h0000,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b0,8'hCD,1'b0},
      '{1'b1,6'h0C,16'h0000,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b0,8'hCD,1'b0},
      '{1'b0,6'h20,16'h0000,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b0,8'hCD,1'b0},
      '{1'b1,6'h10,16'h0011,1'b0,8'h00,1'b1, 1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b0,8'h11,1'b0},
      '{1'b1,6'h10,16'h0022,1'b0,8'h00,1'b1, 1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b0,8'h22,1'b0},
      '{1'b1,6'h20,16'h1200,1'b1,8'h3C,1'b0, 1'b1,16'h125A,1'b0, 1'b1,1'b0,1'b0,8'h22,1'b0},
      '{1'b1,6'h20,16'hFF00,1'b0,8'h00,1'b0, 1'b1,16'hFF3C,1'b0, 1'b0,1'b0,1'b0,8'h22,1'b0},
      '{1'b1,6'h02,16'h0000,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b1,8'h22,1'b0},
      '{1'b0,6'h00,16'h0000,1'b0,8'h00,1'b1, 1'b0,16'h0000,1'b0, 1'b0,1'b1,1'b1,8'h22,1'b1},
      '{1'b1,6'h10,16'h0044,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b1,8'h44,1'b0},
      '{1'b1,6'h04,16'h0000,1'b0,8'h00,1'b0, 1'b0,16'h0000,1'b0, 1'b0,1'b0,1'b1,8'h44,1'b0}
   };

   task automatic check(input string req, input int step, input logic [15:0] act,
                        input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s step %0d: actual=%h expected=%h", req, step, act, exp);
      end
   endtask

   task automatic idle_inputs();
      exec_io = 1'b0; io_sel = '0; acc_in = '0;
      dev_in_strobe = 1'b0; dev_in_data = '0; dev_out_ack = 1'b0;
   endtask

   task automatic reset_checks(input int tag);
      check("R1 in_flag",  tag, 16'(in_flag),      16'h0);
      check("R1 out_flag", tag, 16'(out_flag),     16'h1);
      check("R1 int_en",   tag, 16'(int_en),       16'h0);
      check("R1 out_data", tag, 16'(dev_out_data), 16'h0);
      check("R10 irq",     tag, 16'(irq),          16'h0);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      reset_checks(-1);
      rst_n = 1'b1;
      @(negedge clk);
      reset_checks(-2);

      for (int i = 0; i < NV; i++) begin
         exec_io = VECS[i].ex; io_sel = VECS[i].sel; acc_in = VECS[i].acc;
         dev_in_strobe = VECS[i].stb; dev_in_data = VECS[i].din;
         dev_out_ack = VECS[i].ack;
         #2;
         check("R3/R2 acc_load", i, 16'(acc_load), 16'(VECS[i].e_load));
         if (VECS[i].e_load) check("R3/R9 acc_out", i, acc_out, VECS[i].e_acc);
         check("R5/R2 pc_skip", i, 16'(pc_skip), 16'(VECS[i].e_skip));
         check("R11 seq_clr", i, 16'(seq_clr), 16'(VECS[i].ex));
         @(posedge clk);
         #1;
         check("R3/R7/R9 in_flag", i, 16'(in_flag), 16'(VECS[i].e_fgi));
         check("R4/R8/R9 out_flag", i, 16'(out_flag), 16'(VECS[i].e_fgo));
         check("R6 int_en", i, 16'(int_en), 16'(VECS[i].e_ien));
         check("R4 out_data", i, 16'(dev_out_data), 16'(VECS[i].e_outr));
         check("R10 irq", i, 16'(irq), 16'(VECS[i].e_irq));
         @(negedge clk);
      end

      // R7: load a character, offer a second while full, read must return the first
      idle_inputs();
      dev_in_strobe = 1'b1; dev_in_data = 8'hA1;
      @(negedge clk);
      dev_in_data = 8'hB2;
      @(negedge clk);
      idle_inputs();
      exec_io = 1'b1; io_sel = 6'h20; acc_in = 16'h0F00;
      #2;
      check("R7 held char", 100, acc_out, 16'h0FA1);
      @(negedge clk);
      idle_inputs();

      // R1: reset mid-run after state has moved
      exec_io = 1'b1; io_sel = 6'h10; acc_in = 16'h00EE;
      @(negedge clk);
      io_sel = 6'h02;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      reset_checks(101);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule